// File: doc/BRIEF.md
# Banked Process Context Switch Controller

This block is the control slice of a small 16-bit processor. The processor runs one supervisor context and up to three user processes. The slice decodes the system instructions that share the jump opcode, keeps a separate program counter for every process ID, and forms each fetch address by putting the active process ID above the local program counter. The memory is therefore split into four equal quadrants, and the supervisor always owns quadrant 0.

The supervisor loop works as follows. It first takes a process ID from the external scheduler (dequeue), then hands the processor to that process (return-from-interrupt style hand-off). A user process keeps the processor for a fixed quantum of instructions, or until it executes the halt instruction. Control then falls back to the supervisor, which continues with the instruction after its hand-off. The register-bank select follows the active process ID so that the register file can keep one bank per context. The ALU, the register contents and the memories stay outside this block. The sequential next PC comes in from an external incrementer, and branch decisions come in from the datapath.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the fetch address is 0, the active PID and the bank select are 0, and all three strobes are low. Reset also clears every saved PC.
- R2: The fetch address is {active PID, saved PC of that PID}. The bank select and the PID output equal the active PID.
- R3: An instruction with bits [15:12]=1000 and bits [11:8]=0000 is a jump: the next PC is instr[5:0]. Any other opcode with branch_taken high loads branch_target. Otherwise the next PC is seq_pc.
- R4: Sub-opcode 1000 (dequeue) in supervisor context raises deq_o for that cycle. The scheduler PID is captured and appears on next_pid_o from the following cycle.
- R5: Sub-opcode 1100 in supervisor context with a nonzero captured PID raises rti_o. The next cycle runs that PID. The supervisor PC is saved as seq_pc.
- R6: After a hand-off, the user process executes exactly 16 instructions. The next fetch then comes from the supervisor, at the instruction after its hand-off.
- R7: A process that is handed the processor again resumes at the PC that followed its last executed instruction.
- R8: Sub-opcode 1111 in user context pulses halt_o for one cycle. The next cycle runs the supervisor.
- R9: A system instruction whose sub-opcode is not 0000, 1000, 1100 or 1111 is a no-op. It advances to seq_pc even when branch_taken is high.
- R10: In user context, dequeue and hand-off raise no strobe, leave next_pid_o and the context unchanged, and advance the PC.
- R11: In supervisor context, halt, and a hand-off while the captured PID is 0, are no-ops. Neither raises a strobe and both advance the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction fetched at fetch_addr_o |
| sched_pid | input | 2 | PID offered by the scheduler |
| branch_taken | input | 1 | Datapath branch decision for this instruction |
| branch_target | input | 6 | Local branch target |
| seq_pc | input | 6 | Sequential next local PC |
| fetch_addr_o | output | 8 | Instruction fetch address |
| pid_o | output | 2 | Active PID |
| reg_bank_o | output | 2 | Register bank select |
| next_pid_o | output | 2 | Captured PID, to be stored at data address 0 |
| deq_o | output | 1 | Dequeue strobe |
| rti_o | output | 1 | Hand-off strobe |
| halt_o | output | 1 | User halt strobe |

## Verification
A wrong saved PC or a wrong active PID shows up in the very next fetch address. The quadrant bits give away a wrong context, and the low bits give away a lost or stale resume point. A miscounted quantum moves the return to the supervisor by whole cycles, so the bench follows every fetch address across each slice rather than checking only the end points. A strobe decoded in the wrong context appears in the same cycle as the offending instruction. A wrong captured PID appears on next_pid_o one cycle after the dequeue and again as the quadrant of the first user fetch.

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl #(
  parameter int PCW     = 6,
  parameter int QUANTUM = 16,
  localparam int CW     = $clog2(QUANTUM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    instr,
  input  logic [1:0]     sched_pid,
  input  logic           branch_taken,
  input  logic [PCW-1:0] branch_target,
  input  logic [PCW-1:0] seq_pc,
  output logic [PCW+1:0] fetch_addr_o,
  output logic [1:0]     pid_o,
  output logic [1:0]     reg_bank_o,
  output logic [1:0]     next_pid_o,
  output logic           deq_o,
  output logic           rti_o,
  output logic           halt_o
);

  logic [1:0]     pid_q, sel_q;
  logic [PCW-1:0] pc_q [4];
  logic [CW-1:0]  cnt_q;
  logic [PCW-1:0] next_pc;

  wire       is_sys  = instr[15:12] == 4'b1000;
  wire [3:0] sub     = instr[11:8];
  wire       is_jmp  = is_sys && sub == 4'b0000;
  wire       is_deq  = is_sys && sub == 4'b1000;
  wire       is_rti  = is_sys && sub == 4'b1100;
  wire       is_halt = is_sys && sub == 4'b1111;
  wire       user    = pid_q != 2'd0;
  wire       expire  = user && cnt_q == CW'(QUANTUM - 1);

  assign deq_o        = is_deq && !user;
  assign rti_o        = is_rti && !user && sel_q != 2'd0;
  assign halt_o       = is_halt && user;
  assign pid_o        = pid_q;
  assign reg_bank_o   = pid_q;
  assign next_pid_o   = sel_q;
  assign fetch_addr_o = {pid_q, pc_q[pid_q]};

  always_comb begin
    if (is_jmp)                     next_pc = instr[PCW-1:0];
    else if (!is_sys && branch_taken) next_pc = branch_target;
    else                            next_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid_q <= 2'd0;
      sel_q <= 2'd0;
      cnt_q <= '0;
      for (int i = 0; i < 4; i++) pc_q[i] <= '0;
    end else begin
      pc_q[pid_q] <= next_pc;
      if (deq_o) sel_q <= sched_pid;
      if (rti_o) begin
        pid_q <= sel_q;
        cnt_q <= '0;
      end else if (user) begin
        cnt_q <= cnt_q + 1'b1;
        if (halt_o || expire) pid_q <= 2'd0;
      end
    end
  end

endmodule

// File: rtl/ctx_switch_ctrl_chk.sv
module ctx_switch_ctrl_chk #(
  parameter int PCW     = 6,
  parameter int QUANTUM = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     sched_pid,
  input logic [PCW+1:0] fetch_addr_o,
  input logic [1:0]     pid_o,
  input logic [1:0]     next_pid_o,
  input logic           deq_o,
  input logic           rti_o,
  input logic           halt_o
);

  logic [$clog2(QUANTUM+1):0] ucnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           ucnt <= '0;
    else if (rti_o)       ucnt <= '0;
    else if (pid_o != 0)  ucnt <= ucnt + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (fetch_addr_o == '0 && pid_o == 2'd0));

  assert_deq_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    deq_o |=> next_pid_o == $past(sched_pid));

  assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rti_o |=> (pid_o == $past(next_pid_o) && pid_o != 2'd0));

  assert_quantum_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pid_o != 2'd0 |-> ucnt < ($clog2(QUANTUM+1)+1)'(QUANTUM));

  assert_halt_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> pid_o == 2'd0);

  assert_user_no_priv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pid_o != 2'd0 |-> (!deq_o && !rti_o));

  assert_super_no_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pid_o == 2'd0 |-> !halt_o);

endmodule

bind ctx_switch_ctrl ctx_switch_ctrl_chk #(.PCW(PCW), .QUANTUM(QUANTUM)) chk_i (
  .clk(clk), .rst_n(rst_n), .sched_pid(sched_pid), .fetch_addr_o(fetch_addr_o),
  .pid_o(pid_o), .next_pid_o(next_pid_o), .deq_o(deq_o), .rti_o(rti_o),
  .halt_o(halt_o)
);

// File: tb/ctx_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module ctx_switch_ctrl_tb_top;

  localparam logic [15:0] NOP  = 16'h1234;
  localparam logic [15:0] DEQ  = 16'h8800;
  localparam logic [15:0] RTI  = 16'h8C00;
  localparam logic [15:0] HALT = 16'h8F00;
  localparam logic [15:0] UND  = 16'h8300;

  typedef struct packed {
    logic [7:0] addr;
    logic [2:0] str;
    logic [1:0] np;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = NOP;
  logic [1:0]  sched_pid = 2'd0;
  logic        branch_taken = 1'b0;
  logic [5:0]  branch_target = '0;
  logic [5:0]  seq_pc = '0;
  logic [7:0]  fetch_addr_o;
  logic [1:0]  pid_o, reg_bank_o, next_pid_o;
  logic        deq_o, rti_o, halt_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t  exq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  ctx_switch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .sched_pid(sched_pid),
    .branch_taken(branch_taken), .branch_target(branch_target), .seq_pc(seq_pc),
    .fetch_addr_o(fetch_addr_o), .pid_o(pid_o), .reg_bank_o(reg_bank_o),
    .next_pid_o(next_pid_o), .deq_o(deq_o), .rti_o(rti_o), .halt_o(halt_o)
  );

  task automatic step(input logic [15:0] ins, input logic [1:0] sp, input logic br,
                      input logic [5:0] tgt, input logic [7:0] ea,
                      input logic [2:0] es, input logic [1:0] enp, input string tag);
    exp_t e;
    @(negedge clk);
    instr = ins; sched_pid = sp; branch_taken = br; branch_target = tgt;
    seq_pc = ea[5:0] + 6'd1;
    e.addr = ea; e.str = es; e.np = enp;
    exq.push_back(e);
    tagq.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (exq.size() > 0) begin
        exp_t  e;
        string t;
        logic [2:0] got;
        e = exq.pop_front();
        t = tagq.pop_front();
        got = {deq_o, rti_o, halt_o};
        checks++;
        if (fetch_addr_o !== e.addr || pid_o !== e.addr[7:6] || reg_bank_o !== e.addr[7:6]
            || got !== e.str || next_pid_o !== e.np) begin
          failures++;
          $display("FAIL %s: addr=%h pid=%0d bank=%0d str=%b np=%0d expected addr=%h str=%b np=%0d",
                   t, fetch_addr_o, pid_o, reg_bank_o, got, next_pid_o, e.addr, e.str, e.np);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (fetch_addr_o !== 8'h00 || pid_o !== 2'd0 || {deq_o, rti_o, halt_o} !== 3'b000) begin
      failures++;
      $display("FAIL R1: addr=%h pid=%0d expected addr=00 pid=0", fetch_addr_o, pid_o);
    end
    rst_n = 1'b1;
    // R1 first cycle after reset, R3 jump
    step(16'h8002, 2'd0, 1'b0, 6'd0, 8'h00, 3'b000, 2'd0, "R1_R3_jmp");
    step(DEQ,      2'd1, 1'b0, 6'd0, 8'h02, 3'b100, 2'd0, "R4_deq");
    step(NOP,      2'd0, 1'b1, 6'd5, 8'h03, 3'b000, 2'd1, "R3_R4_branch");
    step(RTI,      2'd0, 1'b0, 6'd0, 8'h05, 3'b010, 2'd1, "R5_rti");
    // first slice of PID 1: R2, R6, R9, R10
    for (int i = 0; i < 16; i++) begin
      if (i == 3)      step(UND,  2'd0, 1'b1, 6'h20, 8'h40 + 8'(i), 3'b000, 2'd1, "R9_undef_subop");
      else if (i == 5) step(RTI,  2'd0, 1'b0, 6'd0,  8'h40 + 8'(i), 3'b000, 2'd1, "R10_user_rti");
      else if (i == 7) step(DEQ,  2'd3, 1'b0, 6'd0,  8'h40 + 8'(i), 3'b000, 2'd1, "R10_user_deq");
      else             step(NOP,  2'd0, 1'b0, 6'd0,  8'h40 + 8'(i), 3'b000, 2'd1, "R2_R6_slice");
    end
    step(DEQ,  2'd2, 1'b0, 6'd0, 8'h06, 3'b100, 2'd1, "R6_return_super");
    step(RTI,  2'd0, 1'b0, 6'd0, 8'h07, 3'b010, 2'd2, "R5_rti_pid2");
    step(NOP,  2'd0, 1'b0, 6'd0, 8'h80, 3'b000, 2'd2, "R2_pid2");
    step(HALT, 2'd0, 1'b0, 6'd0, 8'h81, 3'b001, 2'd2, "R8_halt");
    step(DEQ,  2'd1, 1'b0, 6'd0, 8'h08, 3'b100, 2'd2, "R8_back_super");
    step(RTI,  2'd0, 1'b0, 6'd0, 8'h09, 3'b010, 2'd1, "R5_rti_pid1");
    // R7 resume, jump inside user quadrant, quantum again (R6)
    step(16'h803E, 2'd0, 1'b0, 6'd0, 8'h50, 3'b000, 2'd1, "R7_resume");
    step(NOP,  2'd0, 1'b0, 6'd0, 8'h7E, 3'b000, 2'd1, "R3_user_jmp");
    step(NOP,  2'd0, 1'b0, 6'd0, 8'h7F, 3'b000, 2'd1, "R6_slice2");
    for (int i = 0; i < 13; i++)
      step(NOP, 2'd0, 1'b0, 6'd0, 8'h40 + 8'(i), 3'b000, 2'd1, "R6_slice2_wrap");
    step(DEQ,  2'd0, 1'b0, 6'd0, 8'h0A, 3'b100, 2'd1, "R6_return2");
    step(RTI,  2'd0, 1'b0, 6'd0, 8'h0B, 3'b000, 2'd0, "R11_rti_pid0");
    step(HALT, 2'd0, 1'b0, 6'd0, 8'h0C, 3'b000, 2'd0, "R11_super_halt");
    step(DEQ,  2'd2, 1'b0, 6'd0, 8'h0D, 3'b100, 2'd0, "R11_advance");
    step(RTI,  2'd0, 1'b0, 6'd0, 8'h0E, 3'b010, 2'd2, "R5_rti_pid2b");
    step(NOP,  2'd0, 1'b0, 6'd0, 8'h82, 3'b000, 2'd2, "R7_R8_resume_after_halt");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule